// File: doc/BRIEF.md
# Vector Configuration Setting Unit

This unit executes the three forms of the vector configuration instruction and holds the vector control state that every later vector operation reads. Each accepted request carries a requested application vector length, a type word, and a destination register index. The type word gives the element width, the register-group multiplier (which may be fractional), and the tail and mask policy bits. The unit works out the largest element count the type allows for a fixed vector register length. The granted length is the smaller of that count and the request. The unit updates the held configuration and returns the granted length for register writeback.

The largest element count comes from shifts alone. The grant may be any value up to that count, not only a power of two. A type the unit cannot honour leaves the state marked illegal, with a granted length of zero.

Top module: `vcfg_unit`

## Requirements
- R1: On an accepted request, the granted length is min(requested length, VLMAX). VLMAX = floor(VLEN * LMUL / SEW). Any value from 0 to VLMAX can be granted, including values that are not powers of two.
- R2: Type word fields are as follows. Bits [2:0] hold the LMUL code: 000=1, 001=2, 010=4, 011=8, 111=1/2, 110=1/4, 101=1/8. Bits [5:3] hold the SEW code: 000=8, 001=16, 010=32, 011=64. Bit 6 is tail-agnostic and bit 7 is mask-agnostic.
- R3: cfg_form selects where the length and type come from.
  - 00 takes both from the register inputs.
  - 01 takes the length from the register and the type from the 11-bit immediate, zero-extended.
  - 10 takes the length from the 5-bit immediate, zero-extended, and the type from immediate bits [9:0]. Bit 10 is ignored in this form.
- R4: Any of the following sets cur_illegal and forces the length, SEW, LMUL and policy outputs to 0:
  - LMUL code 100;
  - an SEW code above log2(ELEN/8);
  - a VLMAX below one element;
  - any nonzero type bit above bit 7;
  - cfg_form 11.
- R5: One cycle after an accepted request with rd_idx != 0, wb_valid pulses for exactly one cycle. In that cycle wb_rd carries rd_idx and wb_vl carries the granted length. With rd_idx = 0, nothing is written back, but the configuration is still updated.
- R6: While cfg_valid is low, every held configuration output keeps its value, whatever the other inputs do.
- R7: During and after reset, cur_illegal is 1 and cur_vl, cur_sew, cur_lmul, the policy bits and wb_valid are all 0.
- R8: For a legal type, the tail and mask policy bits appear on cur_tail_agn and cur_mask_agn. 1 means agnostic and 0 means undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | A configuration request is presented this cycle |
| cfg_form | input | 2 | Instruction form (R3) |
| avl_reg | input | XLEN | Requested length from a register |
| avl_imm | input | 5 | Requested length immediate |
| vtype_reg | input | XLEN | Type word from a register |
| vtype_imm | input | 11 | Type word immediate |
| rd_idx | input | 5 | Destination register index |
| wb_valid | output | 1 | Writeback strobe |
| wb_rd | output | 5 | Writeback register index |
| wb_vl | output | XLEN | Granted length for writeback |
| cur_vl | output | XLEN | Held granted length |
| cur_sew | output | 3 | Held SEW code |
| cur_lmul | output | 3 | Held LMUL code |
| cur_tail_agn | output | 1 | Held tail policy |
| cur_mask_agn | output | 1 | Held mask policy |
| cur_illegal | output | 1 | Held illegal-configuration flag |

## Verification
The bench builds the unit with VLEN=128, ELEN=32 and XLEN=32. The short register length lets a 32-bit element width at LMUL 1/8 fall below one element, so the under-capacity illegal case can be reached. It also leaves LMUL 1/4 at exactly one element. The small ELEN makes a 64-bit element width an illegal code, and the widest grouping (SEW 8, LMUL 8) yields a clamp at 128. The same parameters also reach a 5-bit immediate request of 31 against a VLMAX of 32.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    typedef enum logic [1:0] {
        FORM_RR  = 2'b00,
        FORM_RI  = 2'b01,
        FORM_II  = 2'b10,
        FORM_RSV = 2'b11
    } cfg_form_e;

    localparam int TA_BIT    = 6;
    localparam int MA_BIT    = 7;
    localparam int TYPE_USED = 8;

    localparam logic [2:0] LMUL_RSV = 3'b100;

endpackage

// File: rtl/vcfg_opsel.sv
module vcfg_opsel #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      form,
    input  logic [XLEN-1:0] avl_reg,
    input  logic [4:0]      avl_imm,
    input  logic [XLEN-1:0] vtype_reg,
    input  logic [10:0]     vtype_imm,
    output logic [XLEN-1:0] avl,
    output logic [XLEN-1:0] vtype,
    output logic            form_bad
);
    import vcfg_pkg::*;

    always_comb begin
        avl      = '0;
        vtype    = '0;
        form_bad = 1'b0;
        case (cfg_form_e'(form))
            FORM_RR: begin
                avl   = avl_reg;
                vtype = vtype_reg;
            end
            FORM_RI: begin
                avl   = avl_reg;
                vtype = {{(XLEN-11){1'b0}}, vtype_imm};
            end
            FORM_II: begin
                avl   = {{(XLEN-5){1'b0}}, avl_imm};
                vtype = {{(XLEN-10){1'b0}}, vtype_imm[9:0]};
            end
            default: form_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/vcfg_decode.sv
module vcfg_decode #(
    parameter int XLEN = 32,
    parameter int VLEN = 2048,
    parameter int ELEN = 64,
    localparam int MW  = $clog2(VLEN) + 4
) (
    input  logic [XLEN-1:0] vtype,
    input  logic            form_bad,
    output logic [2:0]      sew,
    output logic [2:0]      lmul,
    output logic            ta,
    output logic            ma,
    output logic            illegal,
    output logic [MW-1:0]   vlmax
);
    import vcfg_pkg::*;

    localparam int SEW_MAX = $clog2(ELEN / 8);

    logic [1:0]    up_sh;
    logic [3:0]    dn_sh;
    logic [4:0]    shamt;
    logic [MW-1:0] scaled;
    logic [MW-1:0] fitted;
    logic          rsv_bits;
    logic          sew_bad;

    assign lmul = vtype[2:0];
    assign sew  = vtype[5:3];
    assign ta   = vtype[TA_BIT];
    assign ma   = vtype[MA_BIT];

    always_comb begin
        up_sh    = lmul[2] ? 2'd0 : lmul[1:0];
        dn_sh    = lmul[2] ? (4'd8 - {1'b0, lmul}) : 4'd0;
        shamt    = 5'd3 + {2'b00, sew} + {1'b0, dn_sh};
        scaled   = MW'(VLEN) << up_sh;
        fitted   = scaled >> shamt;
        rsv_bits = |vtype[XLEN-1:TYPE_USED];
        sew_bad  = sew > 3'(SEW_MAX);
        illegal  = form_bad | rsv_bits | sew_bad | (lmul == LMUL_RSV) | (fitted == '0);
        vlmax    = illegal ? '0 : fitted;
    end

endmodule

// File: rtl/vcfg_clamp.sv
module vcfg_clamp #(
    parameter int XLEN = 32,
    parameter int MW   = 15
) (
    input  logic [XLEN-1:0] avl,
    input  logic [MW-1:0]   vlmax,
    output logic [XLEN-1:0] vl
);
    logic [XLEN-1:0] cap;

    always_comb begin
        cap = {{(XLEN-MW){1'b0}}, vlmax};
        vl  = (avl < cap) ? avl : cap;
    end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
    parameter int XLEN = 32,
    parameter int VLEN = 2048,
    parameter int ELEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid,
    input  logic [1:0]      cfg_form,
    input  logic [XLEN-1:0] avl_reg,
    input  logic [4:0]      avl_imm,
    input  logic [XLEN-1:0] vtype_reg,
    input  logic [10:0]     vtype_imm,
    input  logic [4:0]      rd_idx,
    output logic            wb_valid,
    output logic [4:0]      wb_rd,
    output logic [XLEN-1:0] wb_vl,
    output logic [XLEN-1:0] cur_vl,
    output logic [2:0]      cur_sew,
    output logic [2:0]      cur_lmul,
    output logic            cur_tail_agn,
    output logic            cur_mask_agn,
    output logic            cur_illegal
);
    localparam int MW = $clog2(VLEN) + 4;

    typedef struct packed {
        logic [XLEN-1:0] vl;
        logic [2:0]      sew;
        logic [2:0]      lmul;
        logic            ta;
        logic            ma;
        logic            ill;
        logic            wb_v;
        logic [4:0]      wb_rd;
        logic [XLEN-1:0] wb_vl;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] sel_avl;
    logic [XLEN-1:0] sel_vtype;
    logic            sel_bad;
    logic [2:0]      dec_sew;
    logic [2:0]      dec_lmul;
    logic            dec_ta;
    logic            dec_ma;
    logic            dec_ill;
    logic [MW-1:0]   dec_vlmax;
    logic [XLEN-1:0] granted;

    vcfg_opsel #(.XLEN(XLEN)) opsel_i (
        .form      (cfg_form),
        .avl_reg   (avl_reg),
        .avl_imm   (avl_imm),
        .vtype_reg (vtype_reg),
        .vtype_imm (vtype_imm),
        .avl       (sel_avl),
        .vtype     (sel_vtype),
        .form_bad  (sel_bad)
    );

    vcfg_decode #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) decode_i (
        .vtype    (sel_vtype),
        .form_bad (sel_bad),
        .sew      (dec_sew),
        .lmul     (dec_lmul),
        .ta       (dec_ta),
        .ma       (dec_ma),
        .illegal  (dec_ill),
        .vlmax    (dec_vlmax)
    );

    vcfg_clamp #(.XLEN(XLEN), .MW(MW)) clamp_i (
        .avl   (sel_avl),
        .vlmax (dec_vlmax),
        .vl    (granted)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wb_v = 1'b0;
        if (cfg_valid) begin
            st_d.vl    = granted;
            st_d.ill   = dec_ill;
            st_d.sew   = dec_ill ? 3'd0 : dec_sew;
            st_d.lmul  = dec_ill ? 3'd0 : dec_lmul;
            st_d.ta    = dec_ill ? 1'b0 : dec_ta;
            st_d.ma    = dec_ill ? 1'b0 : dec_ma;
            st_d.wb_v  = (rd_idx != 5'd0);
            st_d.wb_rd = rd_idx;
            st_d.wb_vl = granted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ill <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wb_valid     = st_q.wb_v;
    assign wb_rd        = st_q.wb_rd;
    assign wb_vl        = st_q.wb_vl;
    assign cur_vl       = st_q.vl;
    assign cur_sew      = st_q.sew;
    assign cur_lmul     = st_q.lmul;
    assign cur_tail_agn = st_q.ta;
    assign cur_mask_agn = st_q.ma;
    assign cur_illegal  = st_q.ill;

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
    parameter int XLEN = 32,
    parameter int VLEN = 2048
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_valid,
    input logic [1:0]      cfg_form,
    input logic [XLEN-1:0] avl_reg,
    input logic            wb_valid,
    input logic [4:0]      wb_rd,
    input logic [XLEN-1:0] wb_vl,
    input logic [XLEN-1:0] cur_vl,
    input logic [2:0]      cur_sew,
    input logic [2:0]      cur_lmul,
    input logic            cur_tail_agn,
    input logic            cur_mask_agn,
    input logic            cur_illegal
);

    AST_VL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cur_vl <= XLEN'(VLEN)); // R1

    AST_CLAMP_AVL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_form != 2'b10) |=> cur_vl <= $past(avl_reg)); // R1

    AST_IMM_AVL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_form == 2'b10) |=> cur_vl <= XLEN'(31)); // R3

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cur_illegal |-> (cur_vl == '0 && cur_sew == 3'd0 && cur_lmul == 3'd0
                         && !cur_tail_agn && !cur_mask_agn)); // R4

    AST_WB_NONZERO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_rd != 5'd0); // R5

    AST_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_vl == cur_vl); // R5

    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !wb_valid); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> ($stable(cur_vl) && $stable(cur_sew) && $stable(cur_lmul)
                        && $stable(cur_illegal) && $stable(cur_tail_agn)
                        && $stable(cur_mask_agn))); // R6

endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VLEN(VLEN)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_form     (cfg_form),
    .avl_reg      (avl_reg),
    .wb_valid     (wb_valid),
    .wb_rd        (wb_rd),
    .wb_vl        (wb_vl),
    .cur_vl       (cur_vl),
    .cur_sew      (cur_sew),
    .cur_lmul     (cur_lmul),
    .cur_tail_agn (cur_tail_agn),
    .cur_mask_agn (cur_mask_agn),
    .cur_illegal  (cur_illegal)
);

// File: tb/vcfg_unit_tb_top.sv
`timescale 1ns/1ps
module vcfg_unit_tb_top;

    localparam int XLEN = 32;
    localparam int VLEN = 128;
    localparam int ELEN = 32;
    localparam int NVEC = 16;

    typedef struct packed {
        logic [1:0]  form;
        logic [31:0] avl_reg;
        logic [4:0]  avl_imm;
        logic [31:0] vtype_reg;
        logic [10:0] vtype_imm;
        logic [4:0]  rd;
        logic [31:0] exp_vl;
        logic        exp_ill;
        logic [2:0]  exp_sew;
        logic [2:0]  exp_lmul;
        logic        exp_ta;
        logic        exp_ma;
    } vec_t;

    // VLEN=128: SEW8 -> 16*LMUL, SEW16 -> 8*LMUL, SEW32 -> 4*LMUL, SEW64 illegal
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'd10,   5'd0,  32'h10,        11'h0,   5'd1,  32'd4,   1'b0, 3'd2, 3'd0, 1'b0, 1'b0}, // R1 clamp
        '{2'd0, 32'd3,    5'd0,  32'h10,        11'h0,   5'd2,  32'd3,   1'b0, 3'd2, 3'd0, 1'b0, 1'b0}, // R1 odd length
        '{2'd0, 32'd1000, 5'd0,  32'h03,        11'h0,   5'd3,  32'd128, 1'b0, 3'd0, 3'd3, 1'b0, 1'b0}, // R2 LMUL 8
        '{2'd1, 32'd7,    5'd0,  32'hFFFFFFFF,  11'h00F, 5'd6,  32'd4,   1'b0, 3'd1, 3'd7, 1'b0, 1'b0}, // R3 imm type
        '{2'd2, 32'hFFFFFFFF, 5'd31, 32'h0,     11'h401, 5'd4,  32'd31,  1'b0, 3'd0, 3'd1, 1'b0, 1'b0}, // R3 imm avl
        '{2'd1, 32'd7,    5'd0,  32'h0,         11'h401, 5'd5,  32'd0,   1'b1, 3'd0, 3'd0, 1'b0, 1'b0}, // R4 high bit
        '{2'd0, 32'd5,    5'd0,  32'h04,        11'h0,   5'd6,  32'd0,   1'b1, 3'd0, 3'd0, 1'b0, 1'b0}, // R4 lmul 100
        '{2'd0, 32'd5,    5'd0,  32'h18,        11'h0,   5'd7,  32'd0,   1'b1, 3'd0, 3'd0, 1'b0, 1'b0}, // R4 sew 64
        '{2'd0, 32'd5,    5'd0,  32'h15,        11'h0,   5'd8,  32'd0,   1'b1, 3'd0, 3'd0, 1'b0, 1'b0}, // R4 under one
        '{2'd0, 32'd9,    5'd0,  32'h16,        11'h0,   5'd9,  32'd1,   1'b0, 3'd2, 3'd6, 1'b0, 1'b0}, // R2 LMUL 1/4
        '{2'd3, 32'd5,    5'd3,  32'h10,        11'h010, 5'd10, 32'd0,   1'b1, 3'd0, 3'd0, 1'b0, 1'b0}, // R4 form 11
        '{2'd0, 32'd5,    5'd0,  32'h08,        11'h0,   5'd0,  32'd5,   1'b0, 3'd1, 3'd0, 1'b0, 1'b0}, // R5 rd zero
        '{2'd0, 32'd20,   5'd0,  32'hC9,        11'h0,   5'd11, 32'd16,  1'b0, 3'd1, 3'd1, 1'b1, 1'b1}, // R8 both
        '{2'd0, 32'd5,    5'd0,  32'h80000010,  11'h0,   5'd12, 32'd0,   1'b1, 3'd0, 3'd0, 1'b0, 1'b0}, // R4 bit 31
        '{2'd0, 32'd0,    5'd0,  32'h00,        11'h0,   5'd13, 32'd0,   1'b0, 3'd0, 3'd0, 1'b0, 1'b0}, // R1 zero
        '{2'd0, 32'd13,   5'd0,  32'h40,        11'h0,   5'd14, 32'd13,  1'b0, 3'd0, 3'd0, 1'b1, 1'b0}  // R8 tail
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_valid = 1'b0;
    logic [1:0]      cfg_form = '0;
    logic [XLEN-1:0] avl_reg = '0;
    logic [4:0]      avl_imm = '0;
    logic [XLEN-1:0] vtype_reg = '0;
    logic [10:0]     vtype_imm = '0;
    logic [4:0]      rd_idx = '0;
    logic            wb_valid;
    logic [4:0]      wb_rd;
    logic [XLEN-1:0] wb_vl;
    logic [XLEN-1:0] cur_vl;
    logic [2:0]      cur_sew;
    logic [2:0]      cur_lmul;
    logic            cur_tail_agn;
    logic            cur_mask_agn;
    logic            cur_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .cfg_form     (cfg_form),
        .avl_reg      (avl_reg),
        .avl_imm      (avl_imm),
        .vtype_reg    (vtype_reg),
        .vtype_imm    (vtype_imm),
        .rd_idx       (rd_idx),
        .wb_valid     (wb_valid),
        .wb_rd        (wb_rd),
        .wb_vl        (wb_vl),
        .cur_vl       (cur_vl),
        .cur_sew      (cur_sew),
        .cur_lmul     (cur_lmul),
        .cur_tail_agn (cur_tail_agn),
        .cur_mask_agn (cur_mask_agn),
        .cur_illegal  (cur_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R7 illegal"},  32'(cur_illegal),  32'd1);
        chk({tag, " R7 vl"},       cur_vl,            32'd0);
        chk({tag, " R7 sew"},      32'(cur_sew),      32'd0);
        chk({tag, " R7 lmul"},     32'(cur_lmul),     32'd0);
        chk({tag, " R7 policy"},   32'({cur_tail_agn, cur_mask_agn}), 32'd0);
        chk({tag, " R7 wb_valid"}, 32'(wb_valid),     32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held_vl;
        logic [2:0]  held_sew;
        logic [2:0]  held_lmul;
        logic        held_ill;

        repeat (3) @(negedge clk);
        check_reset_state("start");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("post-release");

        for (int i = 0; i < NVEC; i++) begin
            cfg_valid = 1'b1;
            cfg_form  = VECS[i].form;
            avl_reg   = VECS[i].avl_reg;
            avl_imm   = VECS[i].avl_imm;
            vtype_reg = VECS[i].vtype_reg;
            vtype_imm = VECS[i].vtype_imm;
            rd_idx    = VECS[i].rd;
            @(negedge clk);
            cfg_valid = 1'b0;
            chk($sformatf("v%0d R1 vl", i),          cur_vl,               VECS[i].exp_vl);
            chk($sformatf("v%0d R4 illegal", i),     32'(cur_illegal),     32'(VECS[i].exp_ill));
            chk($sformatf("v%0d R2 sew", i),         32'(cur_sew),         32'(VECS[i].exp_sew));
            chk($sformatf("v%0d R2 lmul", i),        32'(cur_lmul),        32'(VECS[i].exp_lmul));
            chk($sformatf("v%0d R8 tail", i),        32'(cur_tail_agn),    32'(VECS[i].exp_ta));
            chk($sformatf("v%0d R8 mask", i),        32'(cur_mask_agn),    32'(VECS[i].exp_ma));
            chk($sformatf("v%0d R5 wb_valid", i),    32'(wb_valid),        32'(VECS[i].rd != 5'd0));
            if (VECS[i].rd != 5'd0) begin
                chk($sformatf("v%0d R5 wb_rd", i),   32'(wb_rd),           32'(VECS[i].rd));
                chk($sformatf("v%0d R5 wb_vl", i),   wb_vl,                VECS[i].exp_vl);
            end
            @(negedge clk);
            chk($sformatf("v%0d R5 pulse ends", i),  32'(wb_valid),        32'd0);
            chk($sformatf("v%0d R6 vl held", i),     cur_vl,               VECS[i].exp_vl);
        end

        // R6: idle cycles with changing inputs leave the configuration untouched
        held_vl   = cur_vl;
        held_sew  = cur_sew;
        held_lmul = cur_lmul;
        held_ill  = cur_illegal;
        for (int k = 0; k < 4; k++) begin
            cfg_form  = 2'(k);
            avl_reg   = 32'd77 + 32'(k);
            avl_imm   = 5'd2;
            vtype_reg = 32'h04;
            vtype_imm = 11'h018;
            rd_idx    = 5'd31;
            @(negedge clk);
            chk("idle R6 vl",      cur_vl,           held_vl);
            chk("idle R6 sew",     32'(cur_sew),     32'(held_sew));
            chk("idle R6 lmul",    32'(cur_lmul),    32'(held_lmul));
            chk("idle R6 illegal", 32'(cur_illegal), 32'(held_ill));
            chk("idle R5 no wb",   32'(wb_valid),    32'd0);
        end

        // R1: back-to-back requests, the later one wins
        cfg_valid = 1'b1; cfg_form = 2'd0; avl_reg = 32'd6; vtype_reg = 32'h08; rd_idx = 5'd3;
        @(negedge clk);
        chk("b2b R1 first vl", cur_vl, 32'd6);
        avl_reg = 32'd50; vtype_reg = 32'h0A;   // SEW16 LMUL4 -> 32
        @(negedge clk);
        cfg_valid = 1'b0;
        chk("b2b R1 second vl", cur_vl, 32'd32);
        chk("b2b R5 wb_vl",     wb_vl,  32'd32);

        // R7: reset in mid-run returns to the illegal state
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("mid-run release");

        finish_run();
    end

endmodule